// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the word address for each beat of a four-beat burst in a synchronous burst memory. A burst starts when either of two active-low start strobes is asserted. One strobe is meant for a processor and the other for a cache controller. The block then captures the external address. After that, each cycle in which the active-low advance input is asserted steps a small counter that acts only on the low-order address bits. The upper address bits stay fixed for the whole burst.

A static order-select input chooses how the low bits move. In interleaved order, each beat's low bits are the start value XORed with the beat count. In linear order, the low bits increment and wrap within the group of four. Every input is registered on the rising clock edge before it is used, and the address and beat position leave the block from registers. A result is therefore visible two edges after its stimulus. The memory array, the byte-write logic and the data path sit outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: While the synchronous active-high reset is applied, and until a later stimulus takes effect, `cur_addr` is 0 and `beat_pos` is 0.
- R2: A low `strobe_proc_n` at a rising edge loads the full `ext_addr` sampled at that edge. The loaded address appears unchanged on `cur_addr`, with `beat_pos` = 0, after the second rising edge.
- R3: A low `strobe_ctrl_n` loads the address exactly as R2 does. Both strobes low together also give a single load.
- R4: With both strobes high, a low `advance_n` increments `beat_pos` by one (modulo 4). A high `advance_n` leaves `beat_pos` and `cur_addr` unchanged, provided `order_interleave` is also unchanged.
- R5: With `order_interleave` = 1, `cur_addr[1:0]` equals the start low bits XOR `beat_pos`. For example, a start of 1 gives 1, 0, 3, 2.
- R6: With `order_interleave` = 0, `cur_addr[1:0]` equals the start low bits plus `beat_pos`, modulo 4. For example, a start of 1 gives 1, 2, 3, 0.
- R7: Outside a load, `cur_addr[ADDR_W-1:2]` never changes.
- R8: A strobe and an advance asserted at the same edge act as a load. The new address starts at beat 0.
- R9: An advance after beat 3 wraps back to beat 0, which is the start address. Advancing never stops.
- R10: Every result is due exactly two rising edges after the edge that samples its inputs. This is one input register stage plus one state/output register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_addr | input | ADDR_W | External start address |
| strobe_proc_n | input | 1 | Burst start from processor side, active low |
| strobe_ctrl_n | input | 1 | Burst start from controller side, active low |
| advance_n | input | 1 | Step to next beat, active low |
| order_interleave | input | 1 | 1 = interleaved (XOR) order, 0 = linear wrap order |
| cur_addr | output | ADDR_W | Current beat word address (registered) |
| beat_pos | output | BEAT_W | Beat count since load, 0..3 (registered) |

## Verification
A stimulus driven before rising edge k lands in the input register at edge k. It reaches `cur_addr` and `beat_pos` at edge k+1. The bench drives on falling edges and keeps its expected values in a two-deep queue. At each falling edge it compares the outputs against the entry computed two stimuli earlier. The checker assertions use a warm-up counter so that their two- and three-cycle history only starts after reset has cleared. The sweep covers both orders, every start value and every strobe combination.

// File: rtl/bag_pkg.sv
package bag_pkg;

  // Low-bit address of a beat, given the captured start bits and the beat count.
  function automatic logic [7:0] order_low(input logic [7:0] start,
                                           input logic [7:0] cnt,
                                           input logic       interleave,
                                           input int         width);
    logic [7:0] mask;
    logic [7:0] r;
    mask = 8'((9'd1 << width) - 9'd1);
    if (interleave) r = start ^ cnt;
    else            r = start + cnt;
    return r & mask;
  endfunction

endpackage

// File: rtl/bag_input_stage.sv
module bag_input_stage #(
  parameter int ADDR_W = 16,
  parameter int NSTB   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSTB-1:0]   stb_n_i,
  input  logic              adv_n_i,
  input  logic              ilv_i,
  output logic [ADDR_W-1:0] addr_q,
  output logic              load_q,
  output logic              adv_q,
  output logic              ilv_q
);

  logic [NSTB-1:0] stb_act_q;

  for (genvar g = 0; g < NSTB; g++) begin : g_stb
    always_ff @(posedge clk) begin
      if (rst) stb_act_q[g] <= 1'b0;
      else     stb_act_q[g] <= ~stb_n_i[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      adv_q  <= 1'b0;
      ilv_q  <= 1'b1;
    end else begin
      addr_q <= addr_i;
      adv_q  <= ~adv_n_i;
      ilv_q  <= ilv_i;
    end
  end

  assign load_q = |stb_act_q;

endmodule

// File: rtl/bag_beat_counter.sv
module bag_beat_counter #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] base_nxt,
  output logic [BEAT_W-1:0] cnt_nxt
);

  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] cnt_q;

  // A strobe has priority over an advance; the counter wraps freely.
  always_comb begin
    base_nxt = base_q;
    cnt_nxt  = cnt_q;
    if (load) begin
      base_nxt = addr;
      cnt_nxt  = '0;
    end else if (adv) begin
      cnt_nxt = cnt_q + BEAT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

endmodule

// File: rtl/bag_order_map.sv
module bag_order_map #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [BEAT_W-1:0] cnt,
  input  logic              interleave,
  output logic [ADDR_W-1:0] addr
);
  import bag_pkg::*;

  logic [7:0] low;

  always_comb begin
    low = order_low(8'(base[BEAT_W-1:0]), 8'(cnt), interleave, BEAT_W);
  end

  assign addr = {base[ADDR_W-1:BEAT_W], low[BEAT_W-1:0]};

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              strobe_proc_n,
  input  logic              strobe_ctrl_n,
  input  logic              advance_n,
  input  logic              order_interleave,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [BEAT_W-1:0] beat_pos
);

  localparam int NSTB = 2;

  logic [ADDR_W-1:0] addr_q;
  logic              load_q;
  logic              adv_q;
  logic              ilv_q;
  logic [ADDR_W-1:0] base_nxt;
  logic [BEAT_W-1:0] cnt_nxt;
  logic [ADDR_W-1:0] addr_nxt;

  bag_input_stage #(.ADDR_W(ADDR_W), .NSTB(NSTB)) u_in (
    .clk    (clk),
    .rst    (rst),
    .addr_i (ext_addr),
    .stb_n_i({strobe_ctrl_n, strobe_proc_n}),
    .adv_n_i(advance_n),
    .ilv_i  (order_interleave),
    .addr_q (addr_q),
    .load_q (load_q),
    .adv_q  (adv_q),
    .ilv_q  (ilv_q)
  );

  bag_beat_counter #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load    (load_q),
    .adv     (adv_q),
    .addr    (addr_q),
    .base_nxt(base_nxt),
    .cnt_nxt (cnt_nxt)
  );

  bag_order_map #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_map (
    .base      (base_nxt),
    .cnt       (cnt_nxt),
    .interleave(ilv_q),
    .addr      (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_addr <= '0;
      beat_pos <= '0;
    end else begin
      cur_addr <= addr_nxt;
      beat_pos <= cnt_nxt;
    end
  end

endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              strobe_proc_n,
  input logic              strobe_ctrl_n,
  input logic              advance_n,
  input logic              order_interleave,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [BEAT_W-1:0] beat_pos
);

  logic [1:0] warm;
  logic       ld;

  always_ff @(posedge clk) begin
    if (rst)            warm <= 2'd0;
    else if (warm != 3) warm <= warm + 2'd1;
  end

  assign ld = !strobe_proc_n || !strobe_ctrl_n;

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (cur_addr == '0 && beat_pos == '0));

  // R2
  load_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 3 && $past(ld, 2)) |-> (cur_addr == $past(ext_addr, 2) && beat_pos == '0));

  // R4
  advance_step_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 3 && !$past(ld, 2) && !$past(advance_n, 2))
      |-> (beat_pos == BEAT_W'($past(beat_pos) + 1'b1)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 3 && !$past(ld, 2) && $past(advance_n, 2) &&
     $past(order_interleave, 2) == $past(order_interleave, 3))
      |-> $stable(cur_addr) && $stable(beat_pos));

  // R7
  upper_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 3 && !$past(ld, 2)) |-> $stable(cur_addr[ADDR_W-1:BEAT_W]));

endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_chk (.*);

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;

  localparam int AW = 16;
  localparam int BW = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] ext_addr;
  logic          strobe_proc_n;
  logic          strobe_ctrl_n;
  logic          advance_n;
  logic          order_interleave;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] beat_pos;

  int checks   = 0;
  int failures = 0;

  // model state and two-deep expectation queue
  logic [AW-1:0] m_base = '0;
  logic [BW-1:0] m_cnt  = '0;
  logic [AW-1:0] e1_addr, e2_addr;
  logic [BW-1:0] e1_beat, e2_beat;
  string         e1_tag, e2_tag;

  always #10 clk = ~clk;

  burst_addr_gen #(.ADDR_W(AW), .BEAT_W(BW)) i_burst_addr_gen (
    .clk(clk), .rst(rst), .ext_addr(ext_addr),
    .strobe_proc_n(strobe_proc_n), .strobe_ctrl_n(strobe_ctrl_n),
    .advance_n(advance_n), .order_interleave(order_interleave),
    .cur_addr(cur_addr), .beat_pos(beat_pos)
  );

  task automatic check(input string tag, input logic [AW-1:0] ea, input logic [BW-1:0] eb);
    checks++;
    if (cur_addr !== ea || beat_pos !== eb) begin
      failures++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, cur_addr, beat_pos, ea, eb);
    end
  endtask

  // Called at a falling edge: checks the result due from two stimuli ago,
  // applies one stimulus and returns at the next falling edge.
  task automatic step(input logic [AW-1:0] a, input logic sp, input logic sc,
                      input logic adv, input logic ilv, input string tag);
    logic [AW-1:0] ex;
    logic [BW-1:0] lo;
    check(e2_tag, e2_addr, e2_beat);
    if (!sp || !sc) begin
      m_base = a;
      m_cnt  = '0;
    end else if (!adv) begin
      m_cnt = BW'((m_cnt + 1) % 4);
    end
    if (ilv) lo = m_base[1:0] ^ m_cnt;
    else     lo = BW'((m_base[1:0] + m_cnt) % 4);
    ex = {m_base[AW-1:2], lo};
    e2_addr = e1_addr; e2_beat = e1_beat; e2_tag = e1_tag;
    e1_addr = ex;      e1_beat = m_cnt;   e1_tag = tag;
    ext_addr = a; strobe_proc_n = sp; strobe_ctrl_n = sc;
    advance_n = adv; order_interleave = ilv;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [AW-1:0] upper;
    upper = 16'hA5C0;
    rst = 1'b1;
    ext_addr = 16'hFFFF; strobe_proc_n = 1'b0; strobe_ctrl_n = 1'b0;
    advance_n = 1'b0; order_interleave = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset", '0, '0);
    strobe_proc_n = 1'b1; strobe_ctrl_n = 1'b1; advance_n = 1'b1;
    order_interleave = 1'b1;
    rst = 1'b0;
    e1_addr = '0; e1_beat = '0; e1_tag = "R1 after reset";
    e2_addr = '0; e2_beat = '0; e2_tag = "R1 after reset";

    for (int mode = 0; mode < 2; mode++) begin
      for (int sel = 0; sel < 3; sel++) begin
        for (int st = 0; st < 4; st++) begin
          upper = {upper[14:0], upper[15] ^ upper[13]} ^ 16'h0130;
          // R2 / R3 load (sel 0: processor, 1: controller, 2: both)
          step({upper[15:2], 2'(st)}, sel == 1, sel == 0, 1'b1, 1'(mode),
               sel == 1 ? "R3 load ctrl" : (sel == 0 ? "R2 load proc" : "R3 load both"));
          // R5 / R6 order, R9 wrap over six beats, R4 idle gaps, R7 upper fixed
          for (int b = 0; b < 6; b++) begin
            step(~upper, 1'b1, 1'b1, 1'b0, 1'(mode),
                 mode == 1 ? "R5 interleave beat R9" : "R6 linear beat R9");
            if (b == 2) step(16'h1234, 1'b1, 1'b1, 1'b1, 1'(mode), "R4 hold R7");
          end
          // R8 strobe with advance mid-burst
          step(upper ^ 16'h0F0F, sel == 1, sel == 0, 1'b0, 1'(mode), "R8 reload priority");
          step(16'h0000, 1'b1, 1'b1, 1'b0, 1'(mode), "R8 next beat");
        end
      end
    end

    // R10: a load followed by idles must appear exactly on the third compare
    step(16'hBEEF, 1'b0, 1'b1, 1'b1, 1'b0, "R10 latency load");
    step(16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, "R10 idle");
    step(16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, "R10 idle");
    step(16'h0000, 1'b1, 1'b1, 1'b1, 1'b0, "R10 idle");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule